// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Per-Character Error Status

This block recovers characters from an asynchronous serial line and queues each one, together with its own error flags, for a bus-side reader. The line is first brought into the clock domain through a short synchronizer. A falling edge seen on an oversample tick marks a possible start bit. The line is then sampled once in the middle of every bit period, counted in ticks of a 16x oversampling enable. The frame format is taken from plain configuration inputs when the start edge is seen: data width of 5 to 8 bits, optional parity (even or odd), and one or two stop bits.

Each received character enters a receive queue as one entry holding the data byte, a framing-error bit and a parity-error bit. The reader sees the entry at the head of the queue. Its error bits always describe that head character, never the newest arrival. A pulse on the status-write input clears the head's error bits and the sticky overrun flag. With the queue disabled the block acts as a single holding register: a new character replaces an unread one and raises overrun. With the queue enabled and full, the new character is dropped and overrun is raised.

The read port follows valid/ready rules. `rd_valid` stays high and `rd_data`, `rd_fe` and `rd_pe` stay steady while the head is waiting. The only exceptions are a status write, which may lower the flags, and the single-register overwrite case. An entry leaves the queue on any clock edge where `rd_valid` and `rd_ready` are both high. The reader may hold `rd_ready` low for as long as it likes. Characters that arrive during that time fill the queue, and once it is full they count as overruns.

Top module: `uart_rx_stat`

## Requirements
- R1: A start is taken only on a high-to-low line transition seen on an oversample tick. The line is re-sampled after OS_RATE/2 ticks, and if it is high there the start is dropped as a glitch and no character is produced.
- R2: The word-length code `cfg_wlen` selects the data width: 2'b00 gives 5 bits, 2'b01 gives 6, 2'b10 gives 7 and 2'b11 gives 8. Data bits above the selected width read as 0 on `rd_data`.
- R3: A character whose stop bit is sampled low is stored with its framing-error bit set. With `cfg_stop2` high, both stop bits are checked and either one being low sets the bit.
- R4: With `cfg_par_en` high, one parity bit follows the data. It is checked for even parity when `cfg_par_even` is 1 and for odd parity when it is 0. A mismatch stores the character with its parity-error bit set. With parity disabled the parity-error bit is always 0.
- R5: `rd_fe` and `rd_pe` show the error bits of the character at the head of the queue, independent of any later characters.
- R6: A one-cycle pulse on `sts_clr` clears the head entry's error bits and the sticky `rd_ovr` flag.
- R7: With `cfg_fifo_en` high, up to DEPTH characters (default 16) queue in arrival order. A character that arrives while the queue is full and no read takes place is discarded, and `rd_ovr` is set.
- R8: With `cfg_fifo_en` low, the block holds one character. A new character that arrives while one is unread replaces it, and `rd_ovr` is set.
- R9: After reset `rd_valid` and `rd_ovr` are 0. While `rd_valid` is high and `rd_ready` is low, the head entry stays on the port. An entry is removed on each edge where both are high.
- R10: Data bits arrive least significant bit first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| os_tick | input | 1 | Oversample enable, OS_RATE ticks per bit |
| cfg_wlen | input | 2 | Data width code |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd parity |
| cfg_stop2 | input | 1 | Two stop bits |
| cfg_fifo_en | input | 1 | 1 = queue of DEPTH entries, 0 = single holding register |
| sts_clr | input | 1 | Status write pulse, clears error bits and overrun |
| rd_valid | output | 1 | Head character available |
| rd_ready | input | 1 | Reader accepts the head character |
| rd_data | output | 8 | Head character data |
| rd_fe | output | 1 | Framing error of head character |
| rd_pe | output | 1 | Parity error of head character |
| rd_ovr | output | 1 | Sticky overrun flag |

## Verification
The bench builds the block with DEPTH=4, OS_RATE=16 and SYNC_STAGES=2. The shallow queue lets the full-queue drop and overrun be reached after five characters rather than seventeen, so the full, drop and drain corners fit in a short run. The bench mostly holds the oversample enable high every cycle. One frame is sent with the enable firing only every third cycle, which shows that the bit timing follows the tick rather than the clock.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int CHAR_W = 8;

  typedef struct packed {
    logic              fe;
    logic              pe;
    logic [CHAR_W-1:0] data;
  } rx_entry_t;

  typedef enum logic [2:0] {
    RS_IDLE,
    RS_START,
    RS_DATA,
    RS_PAR,
    RS_STOP1,
    RS_STOP2
  } rx_state_t;
endpackage

// File: rtl/rx_sampler.sv
module rx_sampler
  import uart_rx_pkg::*;
#(
  parameter int OS_RATE     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic       line_in,
  input  logic [1:0] cfg_wlen,
  input  logic       cfg_par_en,
  input  logic       cfg_par_even,
  input  logic       cfg_stop2,
  output logic       char_vld,
  output rx_entry_t  char_out,
  output logic [3:0] char_nbits
);
  localparam int CW = $clog2(OS_RATE);
  localparam logic [CW-1:0] MID_C  = CW'(OS_RATE / 2 - 1);
  localparam logic [CW-1:0] LAST_C = CW'(OS_RATE - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   line_s;
  logic                   line_prev;
  rx_state_t              state;
  logic [CW-1:0]          cnt;
  logic [2:0]             bitn;
  logic [CHAR_W-1:0]      shreg;
  logic [3:0]             nbits_q;
  logic                   par_en_q, par_even_q, stop2_q, par_bit_q, fe_q;
  logic [CHAR_W-1:0]      aligned;
  logic                   pe_calc;
  logic                   at_last;

  // input synchronizer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
  end
  assign line_s = sync_q[SYNC_STAGES-1];

  assign aligned = shreg >> (4'd8 - nbits_q);
  assign pe_calc = par_en_q & ((^aligned) ^ par_bit_q ^ ~par_even_q);
  assign at_last = (cnt == LAST_C);
  assign char_nbits = nbits_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= RS_IDLE;
      cnt        <= '0;
      bitn       <= '0;
      shreg      <= '0;
      nbits_q    <= 4'd8;
      par_en_q   <= 1'b0;
      par_even_q <= 1'b0;
      stop2_q    <= 1'b0;
      par_bit_q  <= 1'b0;
      fe_q       <= 1'b0;
      line_prev  <= 1'b1;
      char_vld   <= 1'b0;
      char_out   <= '0;
    end else begin
      char_vld <= 1'b0;
      if (os_tick) begin
        line_prev <= line_s;
        unique case (state)
          RS_IDLE: begin
            if (line_prev && !line_s) begin
              state      <= RS_START;
              cnt        <= '0;
              nbits_q    <= 4'd5 + {2'b00, cfg_wlen};
              par_en_q   <= cfg_par_en;
              par_even_q <= cfg_par_even;
              stop2_q    <= cfg_stop2;
            end
          end
          RS_START: begin
            if (cnt == MID_C) begin
              cnt  <= '0;
              bitn <= '0;
              state <= line_s ? RS_IDLE : RS_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RS_DATA: begin
            if (at_last) begin
              cnt   <= '0;
              shreg <= {line_s, shreg[CHAR_W-1:1]};
              if ({1'b0, bitn} == nbits_q - 4'd1)
                state <= par_en_q ? RS_PAR : RS_STOP1;
              else
                bitn <= bitn + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RS_PAR: begin
            if (at_last) begin
              cnt       <= '0;
              par_bit_q <= line_s;
              state     <= RS_STOP1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RS_STOP1: begin
            if (at_last) begin
              cnt <= '0;
              if (stop2_q) begin
                fe_q  <= ~line_s;
                state <= RS_STOP2;
              end else begin
                char_vld      <= 1'b1;
                char_out.data <= aligned;
                char_out.pe   <= pe_calc;
                char_out.fe   <= ~line_s;
                state         <= RS_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RS_STOP2: begin
            if (at_last) begin
              cnt           <= '0;
              char_vld      <= 1'b1;
              char_out.data <= aligned;
              char_out.pe   <= pe_calc;
              char_out.fe   <= fe_q | ~line_s;
              state         <= RS_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= RS_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       fifo_en,
  input  logic                       push_vld,
  input  rx_entry_t                  push_entry,
  input  logic                       rd_ready,
  input  logic                       clr,
  output logic                       head_vld,
  output rx_entry_t                  head_entry,
  output logic                       ovr,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       eff_full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW = $clog2(DEPTH + 1);

  rx_entry_t     mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          pop, do_push, do_overwrite, do_drop;

  assign head_vld     = (count != '0);
  assign head_entry   = mem[rd_ptr];
  assign eff_full     = fifo_en ? (count == NW'(DEPTH)) : (count != '0);
  assign pop          = head_vld & rd_ready;
  assign do_push      = push_vld & (~eff_full | pop);
  assign do_overwrite = push_vld & eff_full & ~pop & ~fifo_en;
  assign do_drop      = push_vld & eff_full & ~pop & fifo_en;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (clr) begin
      mem[rd_ptr].fe <= 1'b0;
      mem[rd_ptr].pe <= 1'b0;
    end
    if (do_push)      mem[wr_ptr] <= push_entry;
    if (do_overwrite) mem[rd_ptr] <= push_entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovr    <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= ptr_inc(wr_ptr);
      if (pop)     rd_ptr <= ptr_inc(rd_ptr);
      case ({do_push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (do_overwrite | do_drop) ovr <= 1'b1;
      else if (clr)               ovr <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rx_stat.sv
module uart_rx_stat
  import uart_rx_pkg::*;
#(
  parameter int OS_RATE     = 16,
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_line,
  input  logic       os_tick,
  input  logic [1:0] cfg_wlen,
  input  logic       cfg_par_en,
  input  logic       cfg_par_even,
  input  logic       cfg_stop2,
  input  logic       cfg_fifo_en,
  input  logic       sts_clr,
  output logic       rd_valid,
  input  logic       rd_ready,
  output logic [7:0] rd_data,
  output logic       rd_fe,
  output logic       rd_pe,
  output logic       rd_ovr
);
  localparam int NW = $clog2(DEPTH + 1);

  logic               char_vld;
  rx_entry_t          char_entry;
  logic [3:0]         char_nbits;
  rx_entry_t          head_entry;
  logic               head_vld;
  logic [NW-1:0]      fifo_count;
  logic               fifo_full;

  rx_sampler #(.OS_RATE(OS_RATE), .SYNC_STAGES(SYNC_STAGES)) u_smp (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .line_in(rx_line),
    .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en),
    .cfg_par_even(cfg_par_even), .cfg_stop2(cfg_stop2),
    .char_vld(char_vld), .char_out(char_entry), .char_nbits(char_nbits)
  );

  rx_fifo #(.DEPTH(DEPTH)) u_q (
    .clk(clk), .rst_n(rst_n), .fifo_en(cfg_fifo_en),
    .push_vld(char_vld), .push_entry(char_entry),
    .rd_ready(rd_ready), .clr(sts_clr),
    .head_vld(head_vld), .head_entry(head_entry), .ovr(rd_ovr),
    .count(fifo_count), .eff_full(fifo_full)
  );

  assign rd_valid = head_vld;
  assign rd_data  = head_vld ? head_entry.data : '0;
  assign rd_fe    = head_vld & head_entry.fe;
  assign rd_pe    = head_vld & head_entry.pe;
endmodule

// File: rtl/uart_rx_stat_chk.sv
module uart_rx_stat_chk
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cfg_fifo_en,
  input logic                       sts_clr,
  input logic                       rd_valid,
  input logic                       rd_ready,
  input logic [7:0]                 rd_data,
  input logic                       rd_fe,
  input logic                       rd_pe,
  input logic                       rd_ovr,
  input logic                       char_vld,
  input rx_entry_t                  char_entry,
  input logic [3:0]                 char_nbits,
  input logic [$clog2(DEPTH+1)-1:0] fifo_count
);
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= ($clog2(DEPTH+1))'(DEPTH));

  p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    char_vld |-> ((char_entry.data >> char_nbits) == 8'd0));

  p_head_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !sts_clr && (cfg_fifo_en || !char_vld))
      |=> (rd_valid && $stable(rd_data)));

  p_clear_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_clr && !char_vld && !(rd_valid && rd_ready))
      |=> (!rd_ovr && !rd_fe && !rd_pe));

  p_single_ovr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (char_vld && rd_valid && !rd_ready && !cfg_fifo_en) |=> rd_ovr);
endmodule

bind uart_rx_stat uart_rx_stat_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_fifo_en(cfg_fifo_en), .sts_clr(sts_clr),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
  .rd_fe(rd_fe), .rd_pe(rd_pe), .rd_ovr(rd_ovr),
  .char_vld(char_vld), .char_entry(char_entry), .char_nbits(char_nbits),
  .fifo_count(fifo_count)
);

// File: tb/sim_uart_rx_stat.sv
`timescale 1ns/1ps
module sim_uart_rx_stat;
  import uart_rx_pkg::*;

  localparam int TB_DEPTH = 4;
  localparam int TB_OS    = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_line = 1'b1;
  logic       os_tick = 1'b0;
  logic [1:0] cfg_wlen = 2'b11;
  logic       cfg_par_en = 1'b0, cfg_par_even = 1'b0, cfg_stop2 = 1'b0;
  logic       cfg_fifo_en = 1'b1;
  logic       sts_clr = 1'b0;
  logic       rd_valid, rd_ready;
  logic [7:0] rd_data;
  logic       rd_fe, rd_pe, rd_ovr;

  int total = 0;
  int bad   = 0;
  int tick_div = 1;
  int tick_cnt = 0;
  int cyc = 0;
  bit done = 0;
  rx_entry_t exp_q[$];

  always #10 clk = ~clk;

  uart_rx_stat #(.OS_RATE(TB_OS), .DEPTH(TB_DEPTH), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .os_tick(os_tick),
    .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
    .cfg_stop2(cfg_stop2), .cfg_fifo_en(cfg_fifo_en), .sts_clr(sts_clr),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .rd_fe(rd_fe), .rd_pe(rd_pe), .rd_ovr(rd_ovr)
  );

  initial rd_ready = 1'b0;

  always @(posedge clk) begin
    if (tick_cnt >= tick_div - 1) begin
      tick_cnt <= 0;
      os_tick  <= 1'b1;
    end else begin
      tick_cnt <= tick_cnt + 1;
      os_tick  <= 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rd_valid && rd_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected character", rd_data, 0);
      end else begin
        rx_entry_t e;
        e = exp_q.pop_front();
        check(rd_data == e.data, "R7/R10 data order", rd_data, e.data);
        check(rd_fe == e.fe, "R3/R5 framing flag", rd_fe, e.fe);
        check(rd_pe == e.pe, "R4/R5 parity flag", rd_pe, e.pe);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL watchdog R9 actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic hold_bit(input logic v);
    rx_line = v;
    repeat (TB_OS * tick_div) @(posedge clk);
    #1;
  endtask

  task automatic send_frame(input logic [7:0] d, input int nb, input bit pen,
                            input bit even, input bit st2, input bit bad_stop,
                            input bit bad_par, input bit expect_it, input bit cleared);
    logic [7:0] m;
    logic       p;
    rx_entry_t  e;
    m = d & 8'((1 << nb) - 1);
    p = (^m) ^ ~even;
    if (bad_par) p = ~p;
    cfg_wlen = 2'(nb - 5);
    cfg_par_en = pen;
    cfg_par_even = even;
    cfg_stop2 = st2;
    if (expect_it) begin
      e.data = m;
      e.fe   = bad_stop & ~cleared;
      e.pe   = pen & bad_par & ~cleared;
      exp_q.push_back(e);
    end
    hold_bit(1'b0);
    for (int i = 0; i < nb; i++) hold_bit(m[i]);
    if (pen) hold_bit(p);
    hold_bit(~bad_stop);
    if (st2) hold_bit(1'b1);
    hold_bit(1'b1);
  endtask

  task automatic drain();
    for (int i = 0; i < 2000 && exp_q.size() != 0; i++) @(posedge clk);
    #1;
    check(exp_q.size() == 0, "R9 drain", exp_q.size(), 0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(rd_valid == 1'b0, "R9 reset valid", rd_valid, 0);
    check(rd_ovr == 1'b0, "R9 reset overrun", rd_ovr, 0);
    @(posedge clk); #1;
    rd_ready = 1'b1;

    // R10 R2 R3 R4: assorted formats
    send_frame(8'hA5, 8, 0, 0, 0, 0, 0, 1, 0);
    send_frame(8'hF3, 5, 0, 0, 0, 0, 0, 1, 0);   // R2 upper bits zero
    send_frame(8'h55, 7, 1, 1, 1, 0, 0, 1, 0);   // R4 even, two stops
    send_frame(8'h2A, 6, 1, 0, 0, 0, 0, 1, 0);   // R4 odd
    send_frame(8'hC3, 8, 1, 1, 0, 0, 1, 1, 0);   // R4 parity error
    send_frame(8'h3E, 8, 0, 0, 0, 1, 0, 1, 0);   // R3 bad stop
    send_frame(8'h71, 7, 0, 0, 1, 1, 0, 1, 0);   // R3 bad first of two stops
    drain();

    // R1 glitch rejection
    rx_line = 1'b0;
    repeat (4) @(posedge clk);
    #1 rx_line = 1'b1;
    repeat (60) @(posedge clk);
    @(negedge clk);
    check(rd_valid == 1'b0, "R1 glitch rejected", rd_valid, 0);

    // tick enable slower than clock
    @(posedge clk); #1;
    tick_div = 3;
    send_frame(8'h3C, 8, 0, 0, 0, 0, 0, 1, 0);
    drain();
    tick_div = 1;
    repeat (5) @(posedge clk); #1;

    // R5 R6 head status
    rd_ready = 1'b0;
    send_frame(8'h01, 8, 0, 0, 0, 0, 0, 1, 0);
    send_frame(8'h02, 8, 0, 0, 0, 1, 0, 1, 1);
    @(negedge clk);
    check(rd_fe == 1'b0, "R5 head flag not newest", rd_fe, 0);
    check(rd_data == 8'h01, "R9 head held", rd_data, 8'h01);
    @(posedge clk); #1 rd_ready = 1'b1;
    @(posedge clk); #1 rd_ready = 1'b0;
    @(negedge clk);
    check(rd_fe == 1'b1, "R5 head flag follows head", rd_fe, 1);
    @(posedge clk); #1 sts_clr = 1'b1;
    @(posedge clk); #1 sts_clr = 1'b0;
    @(negedge clk);
    check(rd_fe == 1'b0, "R6 clear flag", rd_fe, 0);
    check(rd_valid == 1'b1, "R6 clear keeps char", rd_valid, 1);
    @(posedge clk); #1 rd_ready = 1'b1;
    drain();

    // R7 full queue drops and sets overrun
    rd_ready = 1'b0;
    for (int i = 0; i <= TB_DEPTH; i++)
      send_frame(8'(8'h40 + i), 8, 0, 0, 0, 0, 0, (i < TB_DEPTH), 0);
    @(negedge clk);
    check(rd_ovr == 1'b1, "R7 overrun on full", rd_ovr, 1);
    check(rd_data == 8'h40, "R7 oldest at head", rd_data, 8'h40);
    @(posedge clk); #1 rd_ready = 1'b1;
    drain();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(rd_valid == 1'b0, "R7 dropped char absent", rd_valid, 0);
    @(posedge clk); #1 sts_clr = 1'b1;
    @(posedge clk); #1 sts_clr = 1'b0;
    @(negedge clk);
    check(rd_ovr == 1'b0, "R6 clear overrun", rd_ovr, 0);

    // R8 single holding register
    @(posedge clk); #1;
    rd_ready = 1'b0;
    cfg_fifo_en = 1'b0;
    send_frame(8'h11, 8, 0, 0, 0, 0, 0, 0, 0);
    send_frame(8'h22, 8, 0, 0, 0, 0, 0, 1, 0);
    @(negedge clk);
    check(rd_ovr == 1'b1, "R8 overrun on overwrite", rd_ovr, 1);
    check(rd_data == 8'h22, "R8 newest kept", rd_data, 8'h22);
    @(posedge clk); #1 rd_ready = 1'b1;
    drain();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(rd_valid == 1'b0, "R8 one entry only", rd_valid, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule